// File: doc/BRIEF.md
# SD Host Interrupt Status Register

This block collects the status events of an SD/MMC host controller and turns them into sticky flags, a masked interrupt and a few grouped error indications. The command engine and the data engine each raise single-cycle pulses when something happens. Examples are a response arriving, a transfer finishing, a buffer block becoming ready, a timeout, a framing or CRC problem, or an illegal buffer access. Each pulse sets its flag, and the flag stays set until software clears it.

Two status registers and their two mask registers sit on a small register bus. A write takes effect on the clock edge while `bus_wr` is high, and a read is combinational from `bus_addr`. Software clears a flag by writing 0 to its bit. The buffer-ready flags are set by the engine's event pulse and never by a buffer level, so software may clear one before it empties the buffer without the flag coming back. The command-busy and card-present levels read through live. While busy is high, a new command request is refused.

The register bus carries control and status only, and there is no back-pressure. A write is accepted in the cycle it is presented, and a read never stalls.

Top module: `sdh_irq_status`

## Requirements
- R1: After `rst_n` is asserted, every sticky flag reads 0, every mask bit reads 1 (address 1 reads 0x0003 and address 3 reads 0x07FF), and `irq` is 0.
- R2: An event pulse sets its flag at the next clock edge, and the flag stays set until it is cleared. Address 0 holds bit 0 (response received, `ev_resp`) and bit 1 (access complete, `ev_xfer_done`). Address 2 holds bits 7:0 from `ev_err[7:0]`, bit 8 (buffer read ready), bit 9 (buffer write ready) and bit 10 (clock divider ready).
- R3: A write to address 0 or 2 clears each sticky flag whose data bit is 0 and leaves unchanged each flag whose data bit is 1.
- R4: When an event pulse and a clearing write reach the same flag in the same cycle, the flag ends up set.
- R5: Once the buffer-ready flags (address 2, bits 8 and 9) are cleared, they stay 0 for any number of cycles until the next `ev_rd_ready` or `ev_wr_ready` pulse.
- R6: Address 0 bit 2 always reads `card_present`, and address 2 bit 11 always reads `cmd_busy`, in the same cycle. Writes to either position have no effect.
- R7: Addresses 1 and 3 are read/write masks, with bits above the sticky width reading 0. `irq` is high exactly when some sticky flag is set while its mask bit is 0. A mask bit of 1 disables its flag.
- R8: `err_timeout` is the OR of address 2 bits 1:0. `err_sync` is the OR of bits 4:2 (end bit, CRC, command index). `err_illegal` is the OR of bits 7:5 (illegal access, illegal read, illegal write).
- R9: `cmd_accept` is high only when `cmd_issue` is high and `cmd_busy` is low.
- R10: While `soft_rst_n` is low at a clock edge, every flag clears and every mask bit sets, and this overrides any event pulse arriving in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst_n | input | 1 | Synchronous active-low soft reset of flags and masks |
| bus_addr | input | 2 | Register select: 0 status A, 1 mask A, 2 status B, 3 mask B |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the register at `bus_addr` |
| ev_resp | input | 1 | Response received pulse |
| ev_xfer_done | input | 1 | Access complete pulse |
| ev_err | input | 8 | Error pulses: response timeout, timeout, end bit, CRC, index, illegal access, illegal read, illegal write |
| ev_rd_ready | input | 1 | A block has filled the read buffer |
| ev_wr_ready | input | 1 | The write buffer has emptied |
| ev_clkdiv_ready | input | 1 | Clock divider ready pulse |
| cmd_busy | input | 1 | Command engine busy level |
| card_present | input | 1 | Card detect level |
| cmd_issue | input | 1 | Request to start a new command |
| cmd_accept | output | 1 | Command request granted |
| irq | output | 1 | Interrupt, OR of unmasked flags |
| err_timeout | output | 1 | Any timeout flag set |
| err_sync | output | 1 | Any end bit, CRC or index flag set |
| err_illegal | output | 1 | Any illegal-access flag set |

## Verification
A flag register stuck at the wrong value shows on the next read of its status address and, once that bit is unmasked, on `irq` in the same cycle. A lost set event or a wrong clear therefore becomes visible one edge after the pulse or write that caused it. A corrupt mask shows immediately as a wrong read-back or a wrong `irq` level while one flag is set. Sweeping each bit alone, and then many clear patterns over a full set of flags, gives every bit a distinct signature at the ports.

// File: rtl/sdh_irq_pkg.sv
package sdh_irq_pkg;
  localparam int DATA_W   = 16;
  localparam int A_W      = 2;
  localparam int ERR_W    = 8;
  localparam int B_W      = ERR_W + 3;
  localparam int CARD_BIT = A_W;
  localparam int BUSY_BIT = B_W;
  localparam int RDY_RD   = ERR_W;
  localparam int RDY_WR   = ERR_W + 1;
  localparam int CLK_RDY  = ERR_W + 2;

  typedef enum logic [1:0] {
    REG_STAT_A = 2'd0,
    REG_MASK_A = 2'd1,
    REG_STAT_B = 2'd2,
    REG_MASK_B = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/sdh_flag_bank.sv
module sdh_flag_bank #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         soft_rst_n,
  input  logic [W-1:0] set_i,
  input  logic         flag_wr,
  input  logic         mask_wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] flags_o,
  output logic [W-1:0] mask_o,
  output logic         irq_o
);
  logic [W-1:0] flags;
  logic [W-1:0] mask;

  for (genvar k = 0; k < W; k++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flags[k] <= 1'b0;
        mask[k]  <= 1'b1;
      end else if (!soft_rst_n) begin
        flags[k] <= 1'b0;
        mask[k]  <= 1'b1;
      end else begin
        if (set_i[k])
          flags[k] <= 1'b1;
        else if (flag_wr && !wdata[k])
          flags[k] <= 1'b0;
        if (mask_wr)
          mask[k] <= wdata[k];
      end
    end
  end

  assign flags_o = flags;
  assign mask_o  = mask;
  assign irq_o   = |(flags & ~mask);

  // R4
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst_n && (|set_i)) |=> ((flags & $past(set_i)) == $past(set_i)));
  // R3
  zero_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst_n && flag_wr && (set_i == '0)) |=> ((flags & ~$past(wdata)) == '0));
  // R2
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst_n && !flag_wr && (set_i == '0)) |=> (flags == $past(flags)));
  // R10
  soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_rst_n) |=> ((flags == '0) && (mask == '1)));
endmodule

// File: rtl/sdh_status_read.sv
module sdh_status_read
  import sdh_irq_pkg::*;
(
  input  logic [1:0]        addr,
  input  logic [A_W-1:0]    a_flags,
  input  logic [A_W-1:0]    a_mask,
  input  logic [B_W-1:0]    b_flags,
  input  logic [B_W-1:0]    b_mask,
  input  logic              card,
  input  logic              busy,
  output logic [DATA_W-1:0] rdata
);
  always_comb begin
    rdata = '0;
    unique case (reg_sel_e'(addr))
      REG_STAT_A: begin
        rdata[A_W-1:0] = a_flags;
        rdata[CARD_BIT] = card;
      end
      REG_MASK_A: rdata[A_W-1:0] = a_mask;
      REG_STAT_B: begin
        rdata[B_W-1:0] = b_flags;
        rdata[BUSY_BIT] = busy;
      end
      REG_MASK_B: rdata[B_W-1:0] = b_mask;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/sdh_irq_status.sv
module sdh_irq_status
  import sdh_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst_n,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ev_resp,
  input  logic              ev_xfer_done,
  input  logic [ERR_W-1:0]  ev_err,
  input  logic              ev_rd_ready,
  input  logic              ev_wr_ready,
  input  logic              ev_clkdiv_ready,
  input  logic              cmd_busy,
  input  logic              card_present,
  input  logic              cmd_issue,
  output logic              cmd_accept,
  output logic              irq,
  output logic              err_timeout,
  output logic              err_sync,
  output logic              err_illegal
);
  logic [A_W-1:0] a_set, a_flags, a_mask;
  logic [B_W-1:0] b_set, b_flags, b_mask;
  logic           irq_a, irq_b;
  logic           unused_wbits;

  assign unused_wbits = ^bus_wdata[DATA_W-1:B_W];

  assign a_set = {ev_xfer_done, ev_resp};
  assign b_set = {ev_clkdiv_ready, ev_wr_ready, ev_rd_ready, ev_err};

  sdh_flag_bank #(.W(A_W)) u_bank_a (
    .clk(clk), .rst_n(rst_n), .soft_rst_n(soft_rst_n),
    .set_i(a_set),
    .flag_wr(bus_wr && (bus_addr == REG_STAT_A)),
    .mask_wr(bus_wr && (bus_addr == REG_MASK_A)),
    .wdata(bus_wdata[A_W-1:0]),
    .flags_o(a_flags), .mask_o(a_mask), .irq_o(irq_a)
  );

  sdh_flag_bank #(.W(B_W)) u_bank_b (
    .clk(clk), .rst_n(rst_n), .soft_rst_n(soft_rst_n),
    .set_i(b_set),
    .flag_wr(bus_wr && (bus_addr == REG_STAT_B)),
    .mask_wr(bus_wr && (bus_addr == REG_MASK_B)),
    .wdata(bus_wdata[B_W-1:0]),
    .flags_o(b_flags), .mask_o(b_mask), .irq_o(irq_b)
  );

  sdh_status_read u_read (
    .addr(bus_addr), .a_flags(a_flags), .a_mask(a_mask),
    .b_flags(b_flags), .b_mask(b_mask),
    .card(card_present), .busy(cmd_busy), .rdata(bus_rdata)
  );

  assign irq         = irq_a | irq_b;
  assign err_timeout = |b_flags[1:0];
  assign err_sync    = |b_flags[4:2];
  assign err_illegal = |b_flags[7:5];
  assign cmd_accept  = cmd_issue & ~cmd_busy;

  // R9
  busy_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_busy |-> !cmd_accept);
  // R6
  card_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == REG_STAT_A) |-> (bus_rdata[CARD_BIT] == card_present));
  // R6
  busy_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == REG_STAT_B) |-> (bus_rdata[BUSY_BIT] == cmd_busy));
  // R7
  all_masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((&a_mask) && (&b_mask)) |-> !irq);
endmodule

// File: tb/sim_sdh_irq_status.sv
module sim_sdh_irq_status;
  import sdh_irq_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0, soft_rst_n = 1'b1;
  logic [1:0] bus_addr = 2'd0;
  logic bus_wr = 1'b0;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic ev_resp = 0, ev_xfer_done = 0, ev_rd_ready = 0, ev_wr_ready = 0, ev_clkdiv_ready = 0;
  logic [7:0] ev_err = 8'h0;
  logic cmd_busy = 0, card_present = 0, cmd_issue = 0;
  logic cmd_accept, irq, err_timeout, err_sync, err_illegal;
  int nchk = 0, nerr = 0;
  bit done = 0;
  logic [15:0] d;

  always #2 clk = ~clk;

  sdh_irq_status u0 (.*);

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] v);
    @(negedge clk);
    bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic pulse_b(input logic [10:0] v);
    @(negedge clk);
    ev_err = v[7:0]; ev_rd_ready = v[8]; ev_wr_ready = v[9]; ev_clkdiv_ready = v[10];
    @(negedge clk);
    ev_err = 8'h0; ev_rd_ready = 0; ev_wr_ready = 0; ev_clkdiv_ready = 0;
  endtask

  task automatic pulse_a(input logic [1:0] v);
    @(negedge clk);
    ev_resp = v[0]; ev_xfer_done = v[1];
    @(negedge clk);
    ev_resp = 0; ev_xfer_done = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", nchk + 1, nerr);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(0, d); chk("R1 statA", d, 16'h0000);
    rd(1, d); chk("R1 maskA", d, 16'h0003);
    rd(2, d); chk("R1 statB", d, 16'h0000);
    rd(3, d); chk("R1 maskB", d, 16'h07FF);
    chk("R1 irq", irq, 0);

    // R2 R7 R8 R3: each B flag alone
    for (int i = 0; i < 11; i++) begin
      pulse_b(11'(1 << i));
      repeat (2) @(negedge clk);
      rd(2, d); chk("R2 statB single", d, 1 << i);
      chk("R7 masked irq", irq, 0);
      chk("R8 timeout", err_timeout, (i < 2) ? 1 : 0);
      chk("R8 sync", err_sync, (i >= 2 && i <= 4) ? 1 : 0);
      chk("R8 illegal", err_illegal, (i >= 5 && i <= 7) ? 1 : 0);
      wr(3, 16'h07FF & ~(16'h1 << i));
      chk("R7 unmasked irq", irq, 1);
      wr(3, 16'h07FF ^ (16'h1 << ((i + 1) % 11)));
      chk("R7 other unmasked", irq, 0);
      wr(3, 16'hFFFF);
      rd(3, d); chk("R7 maskB readback", d, 16'h07FF);
      wr(2, 16'h0000);
      rd(2, d); chk("R3 clear B", d, 0);
    end

    // R2 A flags
    for (int i = 0; i < 2; i++) begin
      pulse_a(2'(1 << i));
      rd(0, d); chk("R2 statA single", d, 1 << i);
      wr(1, 16'hFFFF & ~(16'h1 << i));
      rd(1, d); chk("R7 maskA readback", d, 16'h0003 & ~(1 << i));
      chk("R7 irq A", irq, 1);
      wr(1, 16'hFFFF);
      wr(0, 16'h0000);
      rd(0, d); chk("R3 clear A", d, 0);
    end

    // R3 clear pattern sweep
    for (int k = 0; k < 40; k++) begin
      logic [15:0] w;
      w = 16'((k * 16'h0155) ^ (k << 3) ^ (k << 9));
      pulse_b(11'h7FF);
      wr(2, w);
      rd(2, d); chk("R3 pattern", d, w & 16'h07FF);
      wr(2, 16'h0);
    end

    // R4 set beats clear
    pulse_a(2'b11);
    @(negedge clk);
    bus_addr = 0; bus_wdata = 16'h0; bus_wr = 1; ev_resp = 1;
    @(negedge clk);
    bus_wr = 0; ev_resp = 0;
    rd(0, d); chk("R4 set wins", d, 16'h0001);
    wr(0, 16'h0);

    // R5 buffer ready edge semantics
    pulse_b(11'h300);
    wr(2, 16'h0);
    repeat (10) @(negedge clk);
    rd(2, d); chk("R5 stays clear", d, 0);
    pulse_b(11'h100);
    rd(2, d); chk("R5 new edge", d, 16'h0100);
    wr(2, 16'h0);

    // R6 live levels
    card_present = 1; cmd_busy = 1;
    rd(0, d); chk("R6 card", d, 16'h0004);
    rd(2, d); chk("R6 busy", d, 16'h0800);
    wr(0, 16'h0000); wr(2, 16'h0000);
    rd(0, d); chk("R6 card write ignored", d, 16'h0004);
    rd(2, d); chk("R6 busy write ignored", d, 16'h0800);

    // R9 command gating
    cmd_issue = 1; #1;
    chk("R9 busy reject", cmd_accept, 0);
    cmd_busy = 0; #1;
    chk("R9 idle accept", cmd_accept, 1);
    cmd_issue = 0; #1;
    chk("R9 no request", cmd_accept, 0);
    card_present = 0;

    // R10 soft reset over set
    pulse_b(11'h7FF); pulse_a(2'b11);
    wr(1, 16'h0); wr(3, 16'h0);
    chk("R10 pre irq", irq, 1);
    @(negedge clk);
    soft_rst_n = 0; ev_err = 8'hFF; ev_resp = 1;
    @(negedge clk);
    soft_rst_n = 1; ev_err = 8'h0; ev_resp = 0;
    rd(0, d); chk("R10 statA", d, 0);
    rd(1, d); chk("R10 maskA", d, 16'h0003);
    rd(2, d); chk("R10 statB", d, 0);
    rd(3, d); chk("R10 maskB", d, 16'h07FF);
    chk("R10 irq", irq, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule